// File: doc/BRIEF.md
# Power-Management Event and PCI Interrupt Router

This block sits behind a chipset configuration write port. It watches byte writes to a small set of register addresses and acts on two of them. A write to the power-management control register can raise a software-requested power-management event. The event is raised only on a qualified rising edge of the trigger bit. It leaves as a single-cycle pulse on one of four lines: system-management interrupt, non-maskable interrupt, IRQ15 or IRQ10. A two-bit delivery field held in the status register picks the line. A firing event also sets a status nibble, which software clears through the control register.

The second function routes the four PCI interrupt lines INTA to INTD. Two routing registers each hold two 4-bit codes. Each code passes through a fixed, sparse lookup to an ISA IRQ number, and the result drives a registered 4-bit output per line. An output of 0 means the line is not routed.

The event logic is a two-state machine. `EV_IDLE` is the rest state. The transition `idle_to_pulse` is taken on a qualified control write and moves to `EV_PULSE`, which lasts exactly one cycle. The transition `pulse_to_idle` returns to `EV_IDLE` on the following cycle.

Top module: `pm_intx_router`

## Requirements
- R1: After reset all four route outputs are 0, all four event pulses are low, the status nibble is 0, the delivery select is 00, and the stored control value is 0.
- R2: A write to address 0x30 fires an event when the written data has bit 4 = 1, bit 2 = 1 and bit 3 = 1, and the previously stored bit 3 was 0. The pulse is high for exactly the one cycle after the write edge.
- R3: The delivery select is bits 5:4 of the last write to address 0x35. 00 pulses `smi_o`, 01 pulses `nmi_o`, 10 pulses `irq15_o` and 11 pulses `irq10_o`. Exactly one line pulses per event.
- R4: A write to 0x30 produces no pulse if stored bit 3 was already 1, or if data bit 4 or bit 2 is 0. Every write to 0x30 updates the stored control value.
- R5: When an event fires, status bits 3:1 become 1 and status bit 0 keeps its value.
- R6: A write to 0x30 with data bit 4 = 0 clears the status nibble to 0000.
- R7: A write to 0x35 changes only the delivery select. The status nibble keeps its value.
- R8: The route code maps to IRQ numbers as follows: 0→0, 1→3, 2→4, 3→7, 4..7→0, 8→9, 9→10, 10→5, 11→6, 12→11, 13→12, 14→14, 15→15. An IRQ number of 0 means disabled.
- R9: A write to 0x42 sets INTA from data bits 3:0 and INTB from bits 7:4. A write to 0x43 sets INTC from bits 3:0 and INTD from bits 7:4. Each route output changes at the write edge and otherwise holds.
- R10: Writes to any other address, and cycles with `cfg_wr_i` low, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Register address |
| cfg_data_i | input | 8 | Write data |
| smi_o | output | 1 | System-management interrupt pulse |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| irq15_o | output | 1 | IRQ15 event pulse |
| irq10_o | output | 1 | IRQ10 event pulse |
| pm_status_o | output | 4 | Event status nibble |
| inta_irq_o | output | 4 | IRQ number for INTA (0 = disabled) |
| intb_irq_o | output | 4 | IRQ number for INTB (0 = disabled) |
| intc_irq_o | output | 4 | IRQ number for INTC (0 = disabled) |
| intd_irq_o | output | 4 | IRQ number for INTD (0 = disabled) |

## Verification
The directed sequences hit the cases that separate a real edge detector from a level check. These are a trigger write with bit 3 already stored as 1, a trigger missing bit 4 or bit 2, and a 0-then-1 sequence repeated under each of the four delivery selects. Those last runs show that the select field decodes to the right line. Every one of the 16 route codes is written into each nibble position of both routing registers. This exposes table errors as well as swapped lanes or swapped nibbles. Randomly weighted writes then mix status clears, select changes and writes to unrelated addresses with triggers, which catches status bits that are lost or cleared by the wrong register.

// File: rtl/pm_intx_pkg.sv
package pm_intx_pkg;

    typedef enum logic [1:0] {
        DLV_SMI   = 2'b00,
        DLV_NMI   = 2'b01,
        DLV_IRQ15 = 2'b10,
        DLV_IRQ10 = 2'b11
    } delivery_e;

    typedef enum logic {
        EV_IDLE  = 1'b0,
        EV_PULSE = 1'b1
    } ev_state_e;

    localparam int unsigned NUM_DLV   = 4;
    localparam int unsigned NUM_LANES = 4;
    localparam int unsigned CODE_W    = 4;

endpackage

// File: rtl/intx_code_map.sv
module intx_code_map
    import pm_intx_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] irq_o
);
    // Code-to-IRQ table packed as 16 nibbles, entry 15 at the top.
    localparam logic [16*CODE_W-1:0] MAP = {
        4'd15, 4'd14, 4'd12, 4'd11, 4'd6, 4'd5, 4'd10, 4'd9,
        4'd0,  4'd0,  4'd0,  4'd0,  4'd7, 4'd4, 4'd3,  4'd0
    };

    always_comb begin
        irq_o = MAP[code_i*CODE_W +: CODE_W];
    end

    // R8: the map never yields an IRQ number that no code maps to
    always_comb begin
        a_r8_legal_irq: assert (!(irq_o inside {4'd1, 4'd2, 4'd8, 4'd13}));
    end
endmodule

// File: rtl/intx_route_lane.sv
module intx_route_lane
    import pm_intx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h42,
    parameter int unsigned NIB_SEL  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] irq_o
);
    localparam int unsigned LSB = NIB_SEL * CODE_W;

    logic              hit;
    logic [CODE_W-1:0] mapped;

    assign hit = wr_i && (addr_i == REG_ADDR);

    intx_code_map u_map (
        .code_i (data_i[LSB +: CODE_W]),
        .irq_o  (mapped)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            irq_o <= '0;
        else if (hit)
            irq_o <= mapped;
    end

    // R9: the route holds when its register is not written
    a_r9_route_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |=> $stable(irq_o));
    // R8: a registered route never carries an unmapped IRQ number
    a_r8_route_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> !(irq_o inside {4'd1, 4'd2, 4'd8, 4'd13}));
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_intx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h30,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h35
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [NUM_DLV-1:0] pulse_o,
    output logic [3:0]         status_o
);
    // Bit positions within the control write
    localparam int unsigned ARM_BIT  = 4;
    localparam int unsigned TRIG_BIT = 3;
    localparam int unsigned QUAL_BIT = 2;
    localparam int unsigned SEL_LSB  = 4;

    ev_state_e         state_q, state_d;
    delivery_e         sel_q;
    logic [DATA_W-1:0] ctl_q;
    logic              ctl_hit, stat_hit, fire;

    assign ctl_hit  = wr_i && (addr_i == CTL_ADDR);
    assign stat_hit = wr_i && (addr_i == STAT_ADDR);
    assign fire     = ctl_hit && data_i[ARM_BIT] && data_i[QUAL_BIT]
                      && data_i[TRIG_BIT] && !ctl_q[TRIG_BIT];

    // Next state: idle_to_pulse on fire, pulse_to_idle otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:  state_d = fire ? EV_PULSE : EV_IDLE;
            EV_PULSE: state_d = fire ? EV_PULSE : EV_IDLE;
            default:  state_d = EV_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            state_q <= EV_IDLE;
        else
            state_q <= state_d;
    end

    // Configuration state: control value, delivery select, status nibble
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q    <= '0;
            sel_q    <= DLV_SMI;
            status_o <= '0;
        end else begin
            if (ctl_hit)
                ctl_q <= data_i;
            if (stat_hit)
                sel_q <= delivery_e'(data_i[SEL_LSB +: 2]);
            if (fire)
                status_o <= status_o | 4'b1110;
            else if (ctl_hit && !data_i[ARM_BIT])
                status_o <= '0;
        end
    end

    // Output process: registered one-hot pulse on the selected line
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pulse_o <= '0;
        end else begin
            pulse_o <= '0;
            if (fire) begin
                unique case (sel_q)
                    DLV_SMI:   pulse_o[0] <= 1'b1;
                    DLV_NMI:   pulse_o[1] <= 1'b1;
                    DLV_IRQ15: pulse_o[2] <= 1'b1;
                    DLV_IRQ10: pulse_o[3] <= 1'b1;
                    default:   pulse_o    <= '0;
                endcase
            end
        end
    end

    // R3: at most one delivery line active
    a_r3_onehot_delivery: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pulse_o));
    // R2: a pulse lasts a single cycle
    a_r2_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pulse_o) |=> !(|pulse_o));
    // R2: the state machine and the pulse register agree
    a_r2_state_tracks_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == EV_PULSE) == (|pulse_o));
    // R5: status bits 3:1 are set whenever a pulse is out
    a_r5_status_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pulse_o) |-> (status_o[3:1] == 3'b111));
    // R6: a control write with bit 4 clear empties the status nibble
    a_r6_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_hit && !data_i[ARM_BIT]) |=> (status_o == 4'b0000));
    // R7: a status-register write leaves the status nibble alone
    a_r7_status_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_hit |=> $stable(status_o));
endmodule

// File: rtl/pm_intx_router.sv
module pm_intx_router
    import pm_intx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR   = 8'h30,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h35,
    parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h42
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_data_i,
    output logic              smi_o,
    output logic              nmi_o,
    output logic              irq15_o,
    output logic              irq10_o,
    output logic [3:0]        pm_status_o,
    output logic [3:0]        inta_irq_o,
    output logic [3:0]        intb_irq_o,
    output logic [3:0]        intc_irq_o,
    output logic [3:0]        intd_irq_o
);
    localparam int unsigned LANES_PER_REG = DATA_W / CODE_W;

    logic [NUM_DLV-1:0] pulses;
    logic [CODE_W-1:0]  lane_irq [NUM_LANES];

    pm_event_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTL_ADDR  (CTL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_event (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (cfg_wr_i),
        .addr_i   (cfg_addr_i),
        .data_i   (cfg_data_i),
        .pulse_o  (pulses),
        .status_o (pm_status_o)
    );

    assign smi_o   = pulses[0];
    assign nmi_o   = pulses[1];
    assign irq15_o = pulses[2];
    assign irq10_o = pulses[3];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        intx_route_lane #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .REG_ADDR (ADDR_W'(ROUTE_BASE + g / LANES_PER_REG)),
            .NIB_SEL  (g % LANES_PER_REG)
        ) u_lane (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .wr_i   (cfg_wr_i),
            .addr_i (cfg_addr_i),
            .data_i (cfg_data_i),
            .irq_o  (lane_irq[g])
        );
    end

    assign inta_irq_o = lane_irq[0];
    assign intb_irq_o = lane_irq[1];
    assign intc_irq_o = lane_irq[2];
    assign intd_irq_o = lane_irq[3];

    // R10: with no write strobe nothing but an ending pulse moves
    a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wr_i |=> ($stable(pm_status_o) && !(|pulses)));
endmodule

// File: tb/test_pm_intx_router.sv
module test_pm_intx_router;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
    logic       smi, nmi, i15, i10;
    logic [3:0] stat, ia, ib, ic, id;

    int checks = 0;
    int fails  = 0;

    // Bench model
    logic [7:0] m_ctl;
    logic [1:0] m_sel;
    logic [3:0] m_stat;
    logic [3:0] m_rt [4];

    always #2.5 clk = ~clk;

    pm_intx_router i_pm_intx_router (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_wr_i    (wr),
        .cfg_addr_i  (addr),
        .cfg_data_i  (data),
        .smi_o       (smi),
        .nmi_o       (nmi),
        .irq15_o     (i15),
        .irq10_o     (i10),
        .pm_status_o (stat),
        .inta_irq_o  (ia),
        .intb_irq_o  (ib),
        .intc_irq_o  (ic),
        .intd_irq_o  (id)
    );

    function automatic logic [3:0] exp_irq(input logic [3:0] c);
        case (c)
            4'd1:  return 4'd3;
            4'd2:  return 4'd4;
            4'd3:  return 4'd7;
            4'd8:  return 4'd9;
            4'd9:  return 4'd10;
            4'd10: return 4'd5;
            4'd11: return 4'd6;
            4'd12: return 4'd11;
            4'd13: return 4'd12;
            4'd14: return 4'd14;
            4'd15: return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pulses();
        return {i10, i15, nmi, smi};
    endfunction

    task automatic check_all(input string req, input logic [3:0] exp_p);
        check({req, " pulses"}, 32'(pulses()), 32'(exp_p));
        check({req, " status"}, 32'(stat), 32'(m_stat));
        check({req, " routes"}, {16'h0, ia, ib, ic, id},
              {16'h0, m_rt[0], m_rt[1], m_rt[2], m_rt[3]});
    endtask

    // One write, then compare the cycle after its edge and the cycle after that
    task automatic do_write(input string req, input logic [7:0] a, input logic [7:0] d);
        logic [3:0] ep;
        logic       f;
        ep = 4'b0;
        f  = (a == 8'h30) && d[4] && d[2] && d[3] && !m_ctl[3];
        if (f) begin
            ep     = 4'b0001 << m_sel;
            m_stat = m_stat | 4'b1110;
        end else if (a == 8'h30 && !d[4]) begin
            m_stat = 4'b0;
        end
        if (a == 8'h30) m_ctl = d;
        if (a == 8'h35) m_sel = d[5:4];
        if (a == 8'h42) begin m_rt[0] = exp_irq(d[3:0]); m_rt[1] = exp_irq(d[7:4]); end
        if (a == 8'h43) begin m_rt[2] = exp_irq(d[3:0]); m_rt[3] = exp_irq(d[7:4]); end
        @(negedge clk);
        wr = 1'b1; addr = a; data = d;
        @(negedge clk);
        wr = 1'b0; addr = $urandom; data = $urandom;
        check_all(req, ep);
        @(negedge clk);
        check({req, " pulse ends"}, 32'(pulses()), 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1489));
        wr = 1'b0; addr = '0; data = '0; rst_n = 1'b0;
        m_ctl = '0; m_sel = '0; m_stat = '0;
        for (int i = 0; i < 4; i++) m_rt[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset", 4'b0);

        // R2/R3: a clean 0 -> 1 trigger under every delivery select
        for (int s = 0; s < 4; s++) begin
            do_write("R3 select", 8'h35, 8'(s << 4));
            do_write("R2 arm low", 8'h30, 8'h14);
            do_write("R2 R3 fire", 8'h30, 8'h1C);
            check("R5 status after fire", 32'(stat), 32'hE);
        end
        // R4: bit 3 already stored as 1
        do_write("R4 no edge", 8'h30, 8'h1C);
        // R6: bit 4 clear empties the status
        do_write("R6 clear", 8'h30, 8'h08);
        check("R6 status zero", 32'(stat), 32'h0);
        // R4: missing qualifier bits
        do_write("R4 setup", 8'h30, 8'h00);
        do_write("R4 no bit2", 8'h30, 8'h18);
        do_write("R4 setup", 8'h30, 8'h10);
        do_write("R4 no bit4", 8'h30, 8'h0C);
        // R7: select write keeps status
        do_write("R2 setup", 8'h30, 8'h14);
        do_write("R2 fire", 8'h30, 8'h1F);
        do_write("R7 keep status", 8'h35, 8'hFF);
        check("R7 status kept", 32'(stat), 32'hE);
        // R8/R9: every code in every nibble position
        for (int c = 0; c < 16; c++) begin
            do_write("R8 R9 low pair", 8'h42, 8'({c[3:0], 4'(15 - c)}));
            do_write("R8 R9 high pair", 8'h43, 8'({4'(15 - c), c[3:0]}));
        end
        // R10: other addresses
        do_write("R10 other", 8'h31, 8'hFF);
        do_write("R10 other", 8'h44, 8'h00);
        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a, d;
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0, 1, 2, 3: a = 8'h30;
                4:          a = 8'h35;
                5:          a = 8'h42;
                6:          a = 8'h43;
                default:    a = 8'($urandom);
            endcase
            d = $urandom;
            if (a == 8'h30 && k < 2) d = d | 8'h14;
            do_write("R2 R4 R5 R6 R9 random", a, d);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule